// File: doc/BRIEF.md
# Two-Stage Programmable Sinc Decimator

This block turns a one-bit delta-sigma modulator stream into signed output words at a much lower, programmable rate. Each modulator bit arrives with a valid strobe and is read as +1 or -1. A fixed fifth-order sinc filter reduces the rate by 64. A second stage then averages R of those intermediate samples. It runs either as a first-order sinc (a boxcar) or as a second-order sinc (a triangular window).

A 3-bit rate code picks R. One select bit picks the order of the second stage. The output is scaled by a per-code reciprocal constant, so a steady input density gives the same full scale for every code and both orders. A one-cycle data-ready pulse marks each new word. When the rate code or the order changes, the second stage starts over.

Top module: `sinc_decim2`

## Requirements
- R1: A steady periodic stream with n ones in every 64 consecutive valid bits yields `dout` = (2n-64)*2^24 within ±4096 LSB, for every rate code and both orders (bit 1 counts +1, bit 0 counts -1).
- R2: The rate code sets R as follows: 7→1, 6→4, 5→12, 4→36, 3→240, 2→288, 1→864, 0→1440. With valid high every cycle and the configuration held, consecutive data-ready pulses are 64·R valid strobes apart.
- R3: The pulse spacing of R2 is the same whether `order2` is 0 (first-order) or 1 (second-order).
- R4: After reset the first five fifth-order outputs are discarded. The first data-ready pulse then comes from valid strobe number 64·(5+R) in first-order mode, or 64·(5+2R) in second-order mode. It is seen two clock cycles after the edge that takes that strobe.
- R5: A change of `rate_code` or `order2` clears the second stage. The first output taken after the change counts as sample one. The next pulse follows sample R (first-order) or sample 2R (second-order), with the same two-cycle latency.
- R6: With R=1 (code 7), `dout` equals the fifth-order output exactly, with no rounding error.
- R7: `dready` is high for single cycles only, and `dout` keeps its value while `dready` is low.
- R8: While `rst` is high, `dready` is 0 and `dout` is 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| mod_valid | input | 1 | Strobe qualifying mod_bit |
| rate_code | input | 3 | Second-stage ratio code |
| order2 | input | 1 | 0 = first-order, 1 = second-order second stage |
| dout | output | OW (32) | Signed filtered word |
| dready | output | 1 | One-cycle pulse marking a new dout |

## Verification
The assertions assume the rate code and order bit change only between pulses, and that `rst` is high from time zero. Under those assumptions the count of intermediate samples between pulses is a property of the input schedule alone. Stimulus always begins with a reset. Changes happen only at falling edges, with valid held high across every test that measures strobe counts exactly. Random bit patterns are periodic in 64, so the ideal output is exact and independent of phase.

// File: rtl/sinc_decim2.sv
module sinc_decim2 #(
  parameter int W1 = 32,
  parameter int W2 = 64,
  parameter int OW = 32,
  parameter int KS = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mod_bit,
  input  logic                 mod_valid,
  input  logic [2:0]           rate_code,
  input  logic                 order2,
  output logic signed [OW-1:0] dout,
  output logic                 dready
);
  localparam int ORD1 = 5;
  localparam int DEC1 = 64;
  localparam int CW1  = $clog2(DEC1);
  localparam int KW   = KS + 2;
  localparam int PW   = W2 + KW + 1;

  function automatic logic [10:0] ratio(input logic [2:0] c);
    case (c)
      3'd7: return 11'd1;
      3'd6: return 11'd4;
      3'd5: return 11'd12;
      3'd4: return 11'd36;
      3'd3: return 11'd240;
      3'd2: return 11'd288;
      3'd1: return 11'd864;
      default: return 11'd1440;
    endcase
  endfunction

  function automatic logic [KW-1:0] kcalc(input logic [3:0] g);
    logic [63:0] r, d;
    r = 64'(ratio(g[2:0]));
    d = g[3] ? r * r : r;
    return KW'(((64'd1 << KS) + d / 2) / d);
  endfunction

  logic [KW-1:0] ktab [16];
  for (genvar g = 0; g < 16; g++) begin : g_k
    assign ktab[g] = kcalc(4'(g));
  end

  logic signed [W1-1:0] x1;
  logic signed [W1-1:0] ig [ORD1];
  logic signed [W1-1:0] dl [ORD1];
  logic signed [W1-1:0] cm [ORD1+1];
  logic [CW1-1:0] cnt1;
  logic s1_dec, s1_v;
  logic [2:0] warm;
  logic signed [W1-1:0] s1_y;

  assign x1    = mod_bit ? W1'(1) : '1;
  assign cm[0] = ig[ORD1-1];
  for (genvar k = 0; k < ORD1; k++) begin : g_comb
    assign cm[k+1] = cm[k] - dl[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORD1; k++) begin
        ig[k] <= '0;
        dl[k] <= '0;
      end
      cnt1 <= '0; s1_dec <= 1'b0; s1_v <= 1'b0; warm <= '0; s1_y <= '0;
    end else begin
      s1_dec <= mod_valid && (cnt1 == CW1'(DEC1 - 1));
      s1_v   <= s1_dec && (warm == 3'(ORD1));
      if (mod_valid) begin
        cnt1  <= cnt1 + 1'b1;
        ig[0] <= ig[0] + x1;
        for (int k = 1; k < ORD1; k++) ig[k] <= ig[k] + ig[k-1];
      end
      if (s1_dec) begin
        s1_y <= cm[ORD1];
        for (int k = 0; k < ORD1; k++) dl[k] <= cm[k];
        if (warm != 3'(ORD1)) warm <= warm + 1'b1;
      end
    end
  end

  logic [3:0] cfg, cfg_q;
  logic chg, dec, seen;
  logic [10:0] rr, cnt2;
  logic signed [W2-1:0] xs, i1, i2, f1, e1, e2, i1n, i2n, t2, yv;
  logic signed [PW-1:0] prod;

  assign cfg  = {order2, rate_code};
  assign chg  = cfg != cfg_q;
  assign rr   = ratio(rate_code);
  assign xs   = W2'(s1_y);
  assign i1n  = i1 + xs;
  assign i2n  = i2 + i1n;
  assign t2   = i2n - e1;
  assign yv   = order2 ? (t2 - e2) : (i1n - f1);
  assign prod = PW'(yv) * PW'($signed({1'b0, ktab[cfg]}));
  assign dec  = s1_v && !chg && (cnt2 == rr - 11'd1);

  always_ff @(posedge clk) begin
    cfg_q  <= cfg;
    dready <= 1'b0;
    if (rst || chg) begin
      i1 <= '0; i2 <= '0; f1 <= '0; e1 <= '0; e2 <= '0;
      cnt2 <= '0; seen <= 1'b0;
      if (rst) dout <= '0;
    end else if (s1_v) begin
      i1 <= i1n;
      i2 <= i2n;
      if (dec) begin
        cnt2 <= '0;
        f1 <= i1n; e1 <= i2n; e2 <= t2;
        seen <= 1'b1;
        if (!order2 || seen) begin
          dout   <= prod[KS +: OW];
          dready <= 1'b1;
        end
      end else begin
        cnt2 <= cnt2 + 11'd1;
      end
    end
  end
endmodule

// File: rtl/sinc_decim2_chk.sv
module sinc_decim2_chk #(
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          s1_v,
  input logic          dready,
  input logic [2:0]    rate_code,
  input logic          order2,
  input logic [OW-1:0] dout
);
  function automatic logic [12:0] rof(input logic [2:0] c);
    case (c)
      3'd7: return 13'd1;
      3'd6: return 13'd4;
      3'd5: return 13'd12;
      3'd4: return 13'd36;
      3'd3: return 13'd240;
      3'd2: return 13'd288;
      3'd1: return 13'd864;
      default: return 13'd1440;
    endcase
  endfunction

  logic [3:0] cq;
  logic [12:0] n;
  logic armed, cchg;
  assign cchg = {order2, rate_code} != cq;

  always_ff @(posedge clk) begin
    cq <= {order2, rate_code};
    if (rst || cchg) begin
      n <= '0; armed <= 1'b0;
    end else if (dready) begin
      n <= '0; armed <= 1'b1;
    end else if (s1_v) begin
      n <= n + 13'd1;
    end
  end

  // R7
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst) dready |=> !dready);
  // R7
  hold_val_chk: assert property (@(posedge clk) disable iff (rst) !dready |-> $stable(dout));
  // R2 R3
  interval_chk: assert property (@(posedge clk) disable iff (rst)
    (dready && !cchg && armed) |-> (n == rof(rate_code)));
  // R4 R5
  settle_chk: assert property (@(posedge clk) disable iff (rst)
    (dready && !cchg && !armed) |-> (n == (order2 ? 13'd2 * rof(rate_code) : rof(rate_code))));
  // R8
  reset_out_chk: assert property (@(posedge clk) rst |=> (!dready && dout == '0));
endmodule

bind sinc_decim2 sinc_decim2_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .s1_v(s1_v), .dready(dready),
  .rate_code(rate_code), .order2(order2), .dout(dout)
);

// File: tb/test_sinc_decim2.sv
module test_sinc_decim2;
  localparam int CLK_NS = 10;
  localparam longint TOL = 4096;

  logic clk = 1'b0, rst = 1'b1, mod_bit = 1'b0, mod_valid = 1'b0, order2 = 1'b0;
  logic [2:0] rate_code = 3'd7;
  logic signed [31:0] dout;
  logic dready;

  sinc_decim2 i_sinc_decim2 (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .mod_valid(mod_valid),
    .rate_code(rate_code), .order2(order2), .dout(dout), .dready(dready)
  );

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, ph = 0;
  longint sent = 0;
  logic [63:0] pat = '0;
  bit gaps = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic longint rof(input logic [2:0] c);
    case (c)
      3'd7: return 1;    3'd6: return 4;   3'd5: return 12;  3'd4: return 36;
      3'd3: return 240;  3'd2: return 288; 3'd1: return 864; default: return 1440;
    endcase
  endfunction

  function automatic longint expv(input logic [63:0] p);
    return (longint'($countones(p)) * 2 - 64) * (64'sd1 <<< 24);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp, input longint tol);
    longint d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive();
    mod_valid = gaps ? 1'($urandom_range(0, 1)) : 1'b1;
    mod_bit = pat[ph];
    if (mod_valid) begin
      ph = (ph + 1) % 64;
      sent++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mod_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 dready in reset", longint'(dready), 0, 0);
    chk("R8 dout in reset", longint'(dout), 0, 0);
    @(negedge clk);
    rst = 1'b0; sent = 0; ph = 0;
    drive();
  endtask

  task automatic wait_pulse(output longint at, output longint v, input longint lim);
    logic signed [31:0] h;
    int bad;
    bit done;
    h = dout; bad = 0; done = 0; at = -1; v = 0;
    for (longint i = 0; i < lim && !done; i++) begin
      @(negedge clk);
      if (dready) begin
        at = sent; v = longint'(dout); done = 1;
      end else if (dout != h) begin
        bad++;
      end
      drive();
    end
    chk("R7 dout held between pulses", bad, 0, 0);
    if (!done) chk("R2 pulse timeout", 0, 1, 0);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    chk("R7 single-cycle pulse", longint'(dready), 0, 0);
    drive();
  endtask

  task automatic scen(input logic [2:0] code, input logic ord, input logic [63:0] p, input bit two);
    longint r, k, a1, a2, v1, v2, tol;
    rate_code = code; order2 = ord; pat = p; gaps = 0;
    do_reset();
    r = rof(code); k = ord ? 2 * r : r;
    tol = (code == 3'd7) ? 0 : TOL;
    wait_pulse(a1, v1, 64 * (6 + k) + 20);
    chk("R4 first pulse strobe", a1, 64 * (5 + k) + 2, 0);
    chk(code == 3'd7 ? "R6 exact pass-through" : "R1 settled value", v1, expv(p), tol);
    if (two) begin
      after_pulse();
      wait_pulse(a2, v2, 64 * r + 20);
      chk(ord ? "R3 interval order2" : "R2 interval order1", a2 - a1, 64 * r, 0);
      chk("R1 second value", v2, expv(p), tol);
    end
  endtask

  initial begin
    longint a, v, s0, m, k;
    logic [63:0] rp;
    void'($urandom(32'd4242));

    scen(3'd7, 1'b0, '1, 1);
    scen(3'd7, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 1);
    scen(3'd6, 1'b1, '0, 1);
    scen(3'd5, 1'b0, 64'h0F0F_0000_FFFF_0F0F, 1);

    for (int it = 0; it < 6; it++) begin
      rp = {$urandom, $urandom};
      scen(3'($urandom_range(4, 7)), 1'($urandom_range(0, 1)), rp, 1);
    end

    scen(3'd3, 1'b0, 64'h1234_5678_9ABC_DEF0, 0);
    scen(3'd2, 1'b1, 64'hFFFF_FFFF_0000_0001, 0);

    rate_code = 3'd5; order2 = 1'b0; pat = {$urandom, $urandom}; gaps = 1;
    do_reset();
    wait_pulse(a, v, 64 * 17 * 4);
    chk("R1 value with valid gaps", v, expv(pat), TOL);
    after_pulse();
    gaps = 0;
    wait_pulse(a, v, 64 * 12 * 3);

    @(negedge clk);
    rate_code = 3'd4; order2 = 1'b1;
    s0 = sent;
    drive();
    m = ((s0 + 63) / 64) * 64;
    k = 2 * 36;
    wait_pulse(a, v, 64 * (k + 2) + 20);
    chk("R5 restart after config change", a, m + 64 * (k - 1) + 2, 0);
    chk("R1 value after change", v, expv(pat), TOL);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule